// File: doc/BRIEF.md
# Command Mailbox Handshake Engine

This block sends one command to a helper controller through an 8-bit mailbox register that both sides share. A one-cycle start pulse arrives together with a command byte. The engine keeps only the low four bits of that byte as the request mask. It reads the mailbox and writes it back with the mask bits set, so bits that were already set stay set. It then keeps reading the mailbox until the helper has cleared every requested bit, or until a time limit runs out.

After polling stops, the engine reads the mailbox one more time to decide the result. The command fails in three cases:
- a requested bit is still set;
- the bit four places above a requested bit is set, because the upper nibble carries the helper's error flags;
- any register read reports an error.

The engine ends with a single-cycle done pulse and a pass flag.

The helper side is a plain register port. Reads and writes each use a request/acknowledge handshake, and a read can return an error flag. The time limit is a count of clock cycles. It is derived from two parameters: the clock frequency and the limit in milliseconds.

Top module: `mbx_cmd_engine`

## Requirements
- R1: Only bits [3:0] of `cmd_i` form the request mask. Bits [7:4] have no effect on the written value or on the result.
- R2: After a start, the engine reads the mailbox once. It then writes back the value read, ORed with the mask (value | mask). Bits that were already set are kept.
- R3: After the write, the engine reads the mailbox repeatedly. Once a read shows all requested bits at zero, it makes one final read. If that final read shows no requested bit and no matching error bit, the result is pass.
- R4: Polling lasts at most TIMEOUT_MS × CLK_FREQ_HZ / 1000 cycles. If the requested bits are still set when that limit is reached, the engine stops polling and reports fail.
- R5: In the final read, bit (i+4) is the error flag for request bit i. The result is fail if any such bit is set for a requested i. Error bits of bits that were not requested have no effect.
- R6: A read that returns `rd_err_i` high ends the command at once with fail. This applies to the first read, to a poll read and to the final read. If the first read fails, no write is issued.
- R7: `done_o` is high for exactly one cycle per command. `pass_o` is valid in that cycle.
- R8: A start that arrives while `busy_o` is high is ignored. It causes no extra write and no extra done pulse.
- R9: During and after reset, `done_o`, `busy_o`, `rd_req_o` and `wr_req_o` are low.
- R10: A transfer completes in a cycle where its request and its acknowledge are both high. A request stays high until it is acknowledged, and `wr_data_o` stays stable while the write waits. A read and a write are never requested at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one command |
| cmd_i | input | 8 | Command byte; only the low nibble is used |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result, valid together with done_o |
| rd_req_o | output | 1 | Mailbox read request |
| rd_ack_i | input | 1 | Read acknowledge, carries rd_data_i and rd_err_i |
| rd_data_i | input | 8 | Mailbox value returned by a read |
| rd_err_i | input | 1 | Read failed |
| wr_req_o | output | 1 | Mailbox write request |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_data_o | output | 8 | Value to write to the mailbox |

## Verification
The bench drives the engine against a model of the helper. For each vector, the model is set with:
- a starting mailbox value;
- how many polls pass before the helper clears the request bits, or a setting where it never clears them;
- which error flags the helper raises when it clears;
- which read, if any, returns an error.

A starting value with low bits already set shows whether existing bits are kept, separately from whether the mask is merged in. Error flags placed next to requested bits and next to unrequested bits tell the per-bit error check apart from a blanket check of the whole upper nibble. Read errors placed on the first read, on a poll read and on the final read each stop the sequence at a different point. A helper that never clears the bits and an empty mask cover the timeout and the trivial cases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_STORE = 3'd2,
    ST_POLL  = 3'd3,
    ST_CHECK = 3'd4,
    ST_DONE  = 3'd5
  } mbx_state_e;

endpackage

// File: rtl/mbx_timeout.sv
// Saturating cycle counter bounding the polling phase.
module mbx_timeout #(
  parameter int unsigned LIMIT = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired_o = (cnt_q >= CNT_W'(LIMIT));
  assign cnt_en    = clr_i | (en_i & ~expired_o);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (en_i && !expired_o)
      cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mbx_verdict.sv
// Per-bit comparison of a mailbox value against the request mask.
module mbx_verdict #(
  parameter int unsigned NIB_W = 4
) (
  input  logic [2*NIB_W-1:0] data_i,
  input  logic [NIB_W-1:0]   mask_i,
  output logic               bits_clear_o,
  output logic               err_hit_o
);

  logic [NIB_W-1:0] pend;
  logic [NIB_W-1:0] flag;

  for (genvar b = 0; b < NIB_W; b++) begin : g_bit
    assign pend[b] = mask_i[b] & data_i[b];
    assign flag[b] = mask_i[b] & data_i[b+NIB_W];
  end

  assign bits_clear_o = ~|pend;
  assign err_hit_o    = |flag;

endmodule

// File: rtl/mbx_fsm.sv
// Sequencer: fetch, merge-write, poll, final check, report.
module mbx_fsm
  import mbx_pkg::*;
#(
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_err_i,
  input  logic              wr_ack_i,
  input  logic              bits_clear_i,
  input  logic              err_hit_i,
  input  logic              expired_i,
  output logic [NIB_W-1:0]  mask_o,
  output logic              tmr_clr_o,
  output logic              tmr_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              rd_req_o,
  output logic              wr_req_o,
  output logic [DATA_W-1:0] wr_data_o
);

  mbx_state_e        state_q, state_d;
  logic [NIB_W-1:0]  mask_q, mask_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              pass_q, pass_d;
  logic              rd_done;
  logic              accept;

  assign rd_done = rd_req_o & rd_ack_i;
  assign accept  = (state_q == ST_IDLE) & start_i;

  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    wdata_d = wdata_q;
    pass_d  = pass_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          mask_d  = cmd_i[NIB_W-1:0];
          pass_d  = 1'b0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (rd_done) begin
          if (rd_err_i) begin
            pass_d  = 1'b0;
            state_d = ST_DONE;
          end else begin
            wdata_d = rd_data_i | {{(DATA_W-NIB_W){1'b0}}, mask_q};
            state_d = ST_STORE;
          end
        end
      end
      ST_STORE: begin
        if (wr_ack_i) state_d = ST_POLL;
      end
      ST_POLL: begin
        if (rd_done) begin
          if (rd_err_i) begin
            pass_d  = 1'b0;
            state_d = ST_DONE;
          end else if (bits_clear_i || expired_i) begin
            state_d = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (rd_done) begin
          pass_d  = ~rd_err_i & bits_clear_i & ~err_hit_i;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      wdata_q <= '0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) mask_q <= mask_d;
      if (state_q == ST_FETCH) wdata_q <= wdata_d;
      pass_q <= pass_d;
    end
  end

  assign mask_o    = mask_q;
  assign tmr_clr_o = (state_q == ST_STORE);
  assign tmr_en_o  = (state_q == ST_POLL);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign pass_o    = (state_q == ST_DONE) & pass_q;
  assign rd_req_o  = (state_q == ST_FETCH) | (state_q == ST_POLL) | (state_q == ST_CHECK);
  assign wr_req_o  = (state_q == ST_STORE);
  assign wr_data_o = wdata_q;

endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine #(
  parameter int unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int unsigned TIMEOUT_MS  = 1000,
  parameter int unsigned NIB_W       = 4,
  parameter int unsigned DATA_W      = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] cmd_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              rd_req_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_err_i,
  output logic              wr_req_o,
  input  logic              wr_ack_i,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int unsigned TIMEOUT_CYC = (CLK_FREQ_HZ / 1000) * TIMEOUT_MS;
  localparam int unsigned CNT_W       = $clog2(TIMEOUT_CYC + 1);

  logic [NIB_W-1:0] mask;
  logic             bits_clear;
  logic             err_hit;
  logic             tmr_clr;
  logic             tmr_en;
  logic             expired;

  mbx_fsm #(
    .NIB_W  (NIB_W),
    .DATA_W (DATA_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .cmd_i        (cmd_i),
    .rd_ack_i     (rd_ack_i),
    .rd_data_i    (rd_data_i),
    .rd_err_i     (rd_err_i),
    .wr_ack_i     (wr_ack_i),
    .bits_clear_i (bits_clear),
    .err_hit_i    (err_hit),
    .expired_i    (expired),
    .mask_o       (mask),
    .tmr_clr_o    (tmr_clr),
    .tmr_en_o     (tmr_en),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pass_o       (pass_o),
    .rd_req_o     (rd_req_o),
    .wr_req_o     (wr_req_o),
    .wr_data_o    (wr_data_o)
  );

  mbx_verdict #(
    .NIB_W (NIB_W)
  ) u_verdict (
    .data_i       (rd_data_i),
    .mask_i       (mask),
    .bits_clear_o (bits_clear),
    .err_hit_o    (err_hit)
  );

  mbx_timeout #(
    .LIMIT (TIMEOUT_CYC),
    .CNT_W (CNT_W)
  ) u_timeout (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .en_i      (tmr_en),
    .expired_o (expired)
  );

endmodule

// File: rtl/mbx_cmd_engine_chk.sv
module mbx_cmd_engine_chk #(
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [DATA_W-1:0] cmd_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              rd_req_o,
  input logic              rd_ack_i,
  input logic              rd_err_i,
  input logic              wr_req_o,
  input logic              wr_ack_i,
  input logic [DATA_W-1:0] wr_data_o
);

  logic [NIB_W-1:0] seen_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen_mask <= '0;
    else if (start_i && !busy_o)
      seen_mask <= cmd_i[NIB_W-1:0];
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_req_o)); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o); // R10

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_data_o)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && rd_ack_i && rd_err_i |=> done_o && !pass_o); // R6

  AST_WR_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> ((wr_data_o[NIB_W-1:0] & seen_mask) == seen_mask)); // R2

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_req_o && !wr_req_o && !done_o); // R9

endmodule

bind mbx_cmd_engine mbx_cmd_engine_chk #(
  .NIB_W  (NIB_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .cmd_i     (cmd_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .pass_o    (pass_o),
  .rd_req_o  (rd_req_o),
  .rd_ack_i  (rd_ack_i),
  .rd_err_i  (rd_err_i),
  .wr_req_o  (wr_req_o),
  .wr_ack_i  (wr_ack_i),
  .wr_data_o (wr_data_o)
);

// File: tb/mbx_cmd_engine_bench.sv
`timescale 1ns/1ps
module mbx_cmd_engine_bench;

  localparam int unsigned NEVER = 255;

  typedef struct packed {
    logic [7:0] init;
    logic [7:0] cmd;
    logic [7:0] clr;
    logic [3:0] errb;
    logic [3:0] errat;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'h01, 8'd2,   4'h0, 4'd0},
    '{8'hA0, 8'hF6, 8'd1,   4'h0, 4'd0},
    '{8'h09, 8'h04, 8'd3,   4'h0, 4'd0},
    '{8'h00, 8'h03, 8'd255, 4'h0, 4'd0},
    '{8'h00, 8'h05, 8'd1,   4'h2, 4'd0},
    '{8'h00, 8'h05, 8'd1,   4'h4, 4'd0},
    '{8'h00, 8'h0F, 8'd2,   4'h0, 4'd1},
    '{8'h00, 8'h02, 8'd5,   4'h0, 4'd3},
    '{8'h00, 8'h08, 8'd0,   4'h0, 4'd3},
    '{8'h00, 8'h00, 8'd255, 4'h0, 4'd0},
    '{8'h50, 8'hF0, 8'd255, 4'h0, 4'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] cmd_i = 8'h00;
  logic       busy_o, done_o, pass_o, rd_req_o, wr_req_o;
  logic [7:0] wr_data_o;
  logic       rd_ack_i = 1'b0;
  logic [7:0] rd_data_i = 8'h00;
  logic       rd_err_i = 1'b0;
  logic       wr_ack_i = 1'b0;

  // helper model configuration
  logic       h_load = 1'b1;
  logic [7:0] h_init = 8'h00;
  int         h_clr = 0;
  logic [3:0] h_errb = 4'h0;
  int         h_errat = 0;

  logic [7:0] mbox = 8'h00;
  int         rd_cnt = 0;
  int         poll_cnt = 0;
  int         wr_cnt = 0;
  logic       wr_seen = 1'b0;
  logic [7:0] last_wr = 8'h00;
  int         done_cnt = 0;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mbx_cmd_engine #(
    .CLK_FREQ_HZ (40_000),
    .TIMEOUT_MS  (1)
  ) u_mbx_cmd_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cmd_i     (cmd_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .rd_req_o  (rd_req_o),
    .rd_ack_i  (rd_ack_i),
    .rd_data_i (rd_data_i),
    .rd_err_i  (rd_err_i),
    .wr_req_o  (wr_req_o),
    .wr_ack_i  (wr_ack_i),
    .wr_data_o (wr_data_o)
  );

  // helper controller model
  always @(posedge clk) begin
    rd_ack_i <= 1'b0;
    wr_ack_i <= 1'b0;
    rd_err_i <= 1'b0;
    if (h_load) begin
      mbox     <= h_init;
      rd_cnt   <= 0;
      poll_cnt <= 0;
      wr_cnt   <= 0;
      wr_seen  <= 1'b0;
    end else begin
      if (rd_req_o && !rd_ack_i) begin
        rd_ack_i  <= 1'b1;
        rd_data_i <= mbox;
        rd_cnt    <= rd_cnt + 1;
        if (rd_cnt + 1 == h_errat) rd_err_i <= 1'b1;
        if (wr_seen) begin
          poll_cnt <= poll_cnt + 1;
          if (poll_cnt + 1 == h_clr && h_clr != NEVER)
            mbox <= {mbox[7:4] | h_errb, 4'h0};
        end
      end
      if (wr_req_o && !wr_ack_i) begin
        wr_ack_i <= 1'b1;
        wr_cnt   <= wr_cnt + 1;
        last_wr  <= wr_data_o;
        wr_seen  <= 1'b1;
        if (h_clr == 0) mbox <= {wr_data_o[7:4] | h_errb, 4'h0};
        else            mbox <= wr_data_o;
      end
    end
  end

  always @(negedge clk) if (rst_n && done_o) done_cnt <= done_cnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_pass(input vec_t v);
    logic [3:0] m;
    m = v.cmd[3:0];
    if (v.errat != 0) return 1'b0;
    if (m == 4'h0) return 1'b1;
    if (v.clr == NEVER) return 1'b0;
    return (((v.init[7:4] | v.errb) & m) == 4'h0);
  endfunction

  function automatic string vtag(input int i);
    case (i)
      0: return "R3";
      1: return "R1";
      2: return "R2";
      3: return "R4";
      4: return "R5";
      5: return "R5";
      6: return "R6";
      7: return "R6";
      8: return "R6";
      9: return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic wait_done(input string req, output logic got);
    got = 1'b0;
    for (int n = 0; n < 400; n++) begin
      if (done_o) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
    if (!got) check({req, " done never seen"}, 0, 1);
  endtask

  task automatic load_helper(input vec_t v);
    h_init  = v.init;
    h_clr   = int'(v.clr);
    h_errb  = v.errb;
    h_errat = int'(v.errat);
    h_load  = 1'b1;
    @(negedge clk);
    h_load  = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic got;
    int   d0;
    // R9 reset state
    repeat (3) @(negedge clk);
    check("R9 done", done_o, 0);
    check("R9 busy", busy_o, 0);
    check("R9 rd_req", rd_req_o, 0);
    check("R9 wr_req", wr_req_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 quiet after release", {busy_o, rd_req_o, wr_req_o, done_o}, 0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      load_helper(v);
      start_i = 1'b1;
      cmd_i   = v.cmd;
      @(negedge clk);
      start_i = 1'b0;
      cmd_i   = 8'h00;
      wait_done(vtag(i), got);
      if (got) begin
        check({vtag(i), " pass result"}, pass_o, exp_pass(v));
        check({"R2 write count ", vtag(i)}, wr_cnt, (v.errat == 1) ? 0 : 1);
        if (v.errat != 1)
          check({"R1 R2 written value ", vtag(i)}, last_wr, v.init | {4'h0, v.cmd[3:0]});
        @(negedge clk);
        check("R7 done one cycle", done_o, 0);
        check("R7 idle after done", busy_o, 0);
      end
    end

    // R8: start while busy is ignored
    load_helper('{8'h00, 8'h01, 8'd4, 4'h0, 4'd0});
    d0 = done_cnt;
    start_i = 1'b1;
    cmd_i   = 8'h01;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    start_i = 1'b1;
    cmd_i   = 8'h02;
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R8", got);
    repeat (30) @(negedge clk);
    check("R8 one done pulse", done_cnt - d0, 1);
    check("R8 one write", wr_cnt, 1);
    check("R8 first command value", last_wr, 8'h01);
    check("R8 idle after", busy_o, 0);

    // R9 reset mid-command
    load_helper('{8'h00, 8'h01, 8'd255, 4'h0, 4'd0});
    start_i = 1'b1;
    cmd_i   = 8'h01;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset aborts", {busy_o, rd_req_o, wr_req_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule